// File: doc/BRIEF.md
# Multi-Mode GPIO Interrupt Detector

This block is a bank of general-purpose pins with per-pin event detection. Every pin has four independent detection enables: low level, high level, rising edge and falling edge. Any mix of them may be on at the same time. A detected event sets a sticky bit in an interrupt status register, which software clears by writing ones. A persistent level condition keeps its status bit set for as long as the level is present, so clearing the bit has no lasting effect until the pin leaves the active level.

The bank also holds the output side of the pins. There is a direction register, in which a 1 makes the pin an input, and a data-out register with set and clear aliases. Interrupt enables and wake-up enables each have a read/write register plus set and clear aliases. Two outputs leave the bank: an interrupt request, which is the OR of status AND interrupt enable, and a wake-up request, which is the OR of status AND wake-up enable.

Pad inputs pass through a multi-stage synchroniser before any detection is done. Register access uses a simple single-cycle bus. A write takes effect at the clock edge where select and write are both high. Read data is a combinational decode of the address.

Top module: `gpio_det_bank`

## Requirements
- R1: After reset, status, interrupt enable, wake-up enable, data out and all four detect-enable registers read 0, the direction register (0x20) reads all ones, pad_oe is 0, and irq_req and wake_req are 0.
- R2: The data-in register (0x24) shows a pad change on the second rising clock edge after the change, not on the first.
- R3: Direction register at 0x20: a bit of 1 makes that pin an input, and pad_oe is its bitwise inverse, updated at the write edge.
- R4: Data out at 0x28 is read/write. A write to 0x2C sets the written ones, and a write to 0x30 clears the written ones. Other bits are unchanged, and pad_out follows at the write edge.
- R5: With the rising-edge enable (0x3C) or the falling-edge enable (0x40) set for a pin, that edge on the pad sets the pin's status bit (0x04) on the third edge after the pad change. The bit stays set afterwards.
- R6: With the low-level enable (0x34) or the high-level enable (0x38) set, the status bit is set while the synchronised pin is at that level. After a clear write, it reads 1 again on the following cycle if the level persists, and it clears once the level is gone.
- R7: The status register is write-one-to-clear. Written ones clear their bits, and written zeros leave bits unchanged.
- R8: When a new detection and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: Detect enables combine freely. A pin with both edge enables set reports its rising edge and its falling edge.
- R10: Interrupt enable at 0x08 (read/write), set alias 0x0C, clear alias 0x10. irq_req is the OR of status AND interrupt enable.
- R11: Wake-up enable at 0x14 (read/write), set alias 0x18, clear alias 0x1C. Reading 0x18 returns the wake-up enable register. wake_req is the OR of status AND wake-up enable.
- R12: With no detect enable set, pad activity leaves the status register at 0 and irq_req low, even with every interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output data per pin |
| pad_oe | output | 32 | Output drive enable per pin, 1 = drive |
| irq_req | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Combined wake-up request |

## Verification
A register write is visible on reads and on pad_out, pad_oe, irq_req and wake_req at the falling edge that follows the write edge. A pad change needs two edges to reach the data-in register and three to reach the status register. Because irq_req and wake_req are derived combinationally from registered state, they react in the same cycle as status or an enable. The bench drives all inputs at falling edges and counts the rising edges until each result is due before it samples. It also samples one edge early for data-in, and it lines up a clear write with the exact detection edge to check the collision case.

// File: rtl/gpio_det_pkg.sv
// Package: shared register offsets and sizing for the GPIO detector bank.
// Assumes an 8-bit byte address space; offsets are word aligned.
package gpio_det_pkg;

    localparam int unsigned PIN_COUNT   = 32;
    localparam int unsigned BUS_AW      = 8;
    localparam int unsigned BUS_DW      = 32;

    localparam int unsigned OFS_STAT    = 'h04;
    localparam int unsigned OFS_IEN     = 'h08;
    localparam int unsigned OFS_IEN_SET = 'h0C;
    localparam int unsigned OFS_IEN_CLR = 'h10;
    localparam int unsigned OFS_WEN     = 'h14;
    localparam int unsigned OFS_WEN_SET = 'h18;
    localparam int unsigned OFS_WEN_CLR = 'h1C;
    localparam int unsigned OFS_DIR     = 'h20;
    localparam int unsigned OFS_DIN     = 'h24;
    localparam int unsigned OFS_DOUT    = 'h28;
    localparam int unsigned OFS_DO_SET  = 'h2C;
    localparam int unsigned OFS_DO_CLR  = 'h30;
    localparam int unsigned OFS_DET_LO  = 'h34;
    localparam int unsigned OFS_DET_HI  = 'h38;
    localparam int unsigned OFS_DET_RI  = 'h3C;
    localparam int unsigned OFS_DET_FA  = 'h40;

endpackage

// File: rtl/gpio_det_sync.sv
// Module: multi-stage synchroniser for the pad inputs.
// Assumes STAGES >= 2; every bit is an independent asynchronous signal.
module gpio_det_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else if (g == 0) chain[g] <= async_in;
                else chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign sync_out = chain[LAST];
endmodule

// File: rtl/gpio_det_status.sv
// Module: per-pin event detectors and the sticky status register.
// Assumes sync_in is already synchronised. A detection outranks a clear
// in the same cycle; level sources therefore hold their bit while active.
module gpio_det_status #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_in,
    input  logic [NPINS-1:0] cfg_low,
    input  logic [NPINS-1:0] cfg_high,
    input  logic [NPINS-1:0] cfg_rise,
    input  logic [NPINS-1:0] cfg_fall,
    input  logic [NPINS-1:0] stat_clr,
    output logic [NPINS-1:0] det_hit,
    output logic [NPINS-1:0] status_q
);
    logic [NPINS-1:0] prev_q;

    // Purpose: hold the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            logic lvl_lo, lvl_hi, edg_ri, edg_fa;
            assign lvl_lo = cfg_low[i]  & ~sync_in[i];
            assign lvl_hi = cfg_high[i] &  sync_in[i];
            assign edg_ri = cfg_rise[i] &  sync_in[i] & ~prev_q[i];
            assign edg_fa = cfg_fall[i] & ~sync_in[i] &  prev_q[i];
            assign det_hit[i] = lvl_lo | lvl_hi | edg_ri | edg_fa;
        end
    endgenerate

    // Purpose: sticky status; clear first, then new detections win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~stat_clr) | det_hit;
    end
endmodule

// File: rtl/gpio_det_regs.sv
// Module: register file, set/clear aliases and read decode.
// Assumes NPINS <= DW; single-cycle bus, writes at the select+write edge.
module gpio_det_regs
    import gpio_det_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] status_q,
    input  logic [NPINS-1:0] pin_sync,
    output logic [NPINS-1:0] ien_q,
    output logic [NPINS-1:0] wen_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] cfg_low,
    output logic [NPINS-1:0] cfg_high,
    output logic [NPINS-1:0] cfg_rise,
    output logic [NPINS-1:0] cfg_fall,
    output logic [NPINS-1:0] stat_clr
);
    localparam logic [NPINS-1:0] ALL_IN = '1;

    logic             wr_en;
    logic [NPINS-1:0] wv;

    assign wr_en = bus_sel & bus_wr;
    assign wv    = bus_wdata[NPINS-1:0];

    // Purpose: write-one-to-clear mask for the status register.
    always_comb begin
        stat_clr = '0;
        if (wr_en && bus_addr == AW'(OFS_STAT)) stat_clr = wv;
    end

    // Purpose: writable registers and their set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q    <= '0;
            wen_q    <= '0;
            dir_q    <= ALL_IN;
            dout_q   <= '0;
            cfg_low  <= '0;
            cfg_high <= '0;
            cfg_rise <= '0;
            cfg_fall <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                AW'(OFS_IEN):     ien_q    <= wv;
                AW'(OFS_IEN_SET): ien_q    <= ien_q | wv;
                AW'(OFS_IEN_CLR): ien_q    <= ien_q & ~wv;
                AW'(OFS_WEN):     wen_q    <= wv;
                AW'(OFS_WEN_SET): wen_q    <= wen_q | wv;
                AW'(OFS_WEN_CLR): wen_q    <= wen_q & ~wv;
                AW'(OFS_DIR):     dir_q    <= wv;
                AW'(OFS_DOUT):    dout_q   <= wv;
                AW'(OFS_DO_SET):  dout_q   <= dout_q | wv;
                AW'(OFS_DO_CLR):  dout_q   <= dout_q & ~wv;
                AW'(OFS_DET_LO):  cfg_low  <= wv;
                AW'(OFS_DET_HI):  cfg_high <= wv;
                AW'(OFS_DET_RI):  cfg_rise <= wv;
                AW'(OFS_DET_FA):  cfg_fall <= wv;
                default: ;
            endcase
        end
    end

    // Purpose: read decode; aliases read back their base register.
    always_comb begin
        logic [NPINS-1:0] sel_v;
        sel_v = '0;
        case (bus_addr)
            AW'(OFS_STAT):    sel_v = status_q;
            AW'(OFS_IEN),
            AW'(OFS_IEN_SET),
            AW'(OFS_IEN_CLR): sel_v = ien_q;
            AW'(OFS_WEN),
            AW'(OFS_WEN_SET),
            AW'(OFS_WEN_CLR): sel_v = wen_q;
            AW'(OFS_DIR):     sel_v = dir_q;
            AW'(OFS_DIN):     sel_v = pin_sync;
            AW'(OFS_DOUT),
            AW'(OFS_DO_SET),
            AW'(OFS_DO_CLR):  sel_v = dout_q;
            AW'(OFS_DET_LO):  sel_v = cfg_low;
            AW'(OFS_DET_HI):  sel_v = cfg_high;
            AW'(OFS_DET_RI):  sel_v = cfg_rise;
            AW'(OFS_DET_FA):  sel_v = cfg_fall;
            default:          sel_v = '0;
        endcase
        bus_rdata = '0;
        bus_rdata[NPINS-1:0] = sel_v;
    end
endmodule

// File: rtl/gpio_det_bank.sv
// Module: top of the GPIO detector bank.
// Assumes pad_in is asynchronous; irq_req and wake_req are combinational
// from registered state so they move in the same cycle as status or enables.
module gpio_det_bank
    import gpio_det_pkg::*;
#(
    parameter int unsigned NPINS       = PIN_COUNT,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned AW          = BUS_AW,
    parameter int unsigned DW          = BUS_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq_req,
    output logic             wake_req
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] status_q, det_hit, stat_clr;
    logic [NPINS-1:0] ien_q, wen_q, dir_q, dout_q;
    logic [NPINS-1:0] cfg_low, cfg_high, cfg_rise, cfg_fall;

    gpio_det_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_det_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status_q  (status_q),
        .pin_sync  (pin_sync),
        .ien_q     (ien_q),
        .wen_q     (wen_q),
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .cfg_low   (cfg_low),
        .cfg_high  (cfg_high),
        .cfg_rise  (cfg_rise),
        .cfg_fall  (cfg_fall),
        .stat_clr  (stat_clr)
    );

    gpio_det_status #(.NPINS(NPINS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (pin_sync),
        .cfg_low  (cfg_low),
        .cfg_high (cfg_high),
        .cfg_rise (cfg_rise),
        .cfg_fall (cfg_fall),
        .stat_clr (stat_clr),
        .det_hit  (det_hit),
        .status_q (status_q)
    );

    // Purpose: pad drive and the two combined request outputs.
    assign pad_out  = dout_q;
    assign pad_oe   = ~dir_q;
    assign irq_req  = |(status_q & ien_q);
    assign wake_req = |(status_q & wen_q);
endmodule

// File: rtl/gpio_det_bank_chk.sv
// Module: assertion checker bound to gpio_det_bank.
// Assumes the offsets of gpio_det_pkg and an active-low synchronous reset.
module gpio_det_bank_chk
    import gpio_det_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [NPINS-1:0] pad_out,
    input logic             irq_req,
    input logic             wake_req,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] det_hit,
    input logic [NPINS-1:0] pin_sync,
    input logic [NPINS-1:0] cfg_low,
    input logic [NPINS-1:0] cfg_high
);
    logic [NPINS-1:0] wv, lvl_act;
    logic             wr_stat, wr_set, wr_clr;

    assign wv      = bus_wdata[NPINS-1:0];
    assign lvl_act = (cfg_low & ~pin_sync) | (cfg_high & pin_sync);
    assign wr_stat = bus_sel && bus_wr && bus_addr == AW'(OFS_STAT);
    assign wr_set  = bus_sel && bus_wr && bus_addr == AW'(OFS_DO_SET);
    assign wr_clr  = bus_sel && bus_wr && bus_addr == AW'(OFS_DO_CLR);

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl_act) |=> ((status_q & $past(lvl_act)) == $past(lvl_act))); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status_q & $past(wv) & ~$past(det_hit)) == '0)); // R7

    AST_DETECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|det_hit) |=> ((status_q & $past(det_hit)) == $past(det_hit))); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(det_hit)) == '0)); // R12

    AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pad_out & $past(wv)) == $past(wv))); // R4

    AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pad_out & $past(wv)) == '0)); // R4

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq_req); // R10

    AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !wake_req); // R11
endmodule

bind gpio_det_bank gpio_det_bank_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .irq_req   (irq_req),
    .wake_req  (wake_req),
    .status_q  (status_q),
    .det_hit   (det_hit),
    .pin_sync  (pin_sync),
    .cfg_low   (cfg_low),
    .cfg_high  (cfg_high)
);

// File: tb/gpio_det_bank_tb.sv
// Directed bench for gpio_det_bank: one task per scenario.
module gpio_det_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_req, wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_STAT = 8'h04, A_IEN = 8'h08, A_IEN_S = 8'h0C,
        A_IEN_C = 8'h10, A_WEN = 8'h14, A_WEN_S = 8'h18, A_WEN_C = 8'h1C,
        A_DIR = 8'h20, A_DIN = 8'h24, A_DOUT = 8'h28, A_DO_S = 8'h2C,
        A_DO_C = 8'h30, A_LO = 8'h34, A_HI = 8'h38, A_RI = 8'h3C, A_FA = 8'h40;

    always #5 clk = ~clk;

    gpio_det_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_req(irq_req), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STAT, d); check("R1 status", d, 32'h0);
        rd(A_IEN, d);  check("R1 ien", d, 32'h0);
        rd(A_WEN, d);  check("R1 wen", d, 32'h0);
        rd(A_DIR, d);  check("R1 dir", d, 32'hFFFF_FFFF);
        rd(A_DOUT, d); check("R1 dout", d, 32'h0);
        rd(A_LO, d);   check("R1 low", d, 32'h0);
        rd(A_HI, d);   check("R1 high", d, 32'h0);
        rd(A_RI, d);   check("R1 rise", d, 32'h0);
        rd(A_FA, d);   check("R1 fall", d, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq/wake", {30'b0, irq_req, wake_req}, 32'h0);
    endtask

    task automatic t_data_in();
        logic [31:0] d;
        pins(32'hA5A5_0F0F);
        rd(A_DIN, d); check("R2 one edge", d, 32'h0);
        rd(A_DIN, d); check("R2 two edges", d, 32'hA5A5_0F0F);
        pins(32'h0);
        wait_cyc(4);
    endtask

    task automatic t_direction();
        wr(A_DIR, 32'h0000_FFFF);
        check("R3 pad_oe", pad_oe, 32'hFFFF_0000);
        wr(A_DIR, 32'hFFFF_FFFF);
        check("R3 pad_oe back", pad_oe, 32'h0);
    endtask

    task automatic t_data_out();
        logic [31:0] d;
        wr(A_DOUT, 32'h0000_000F); check("R4 write", pad_out, 32'h0000_000F);
        wr(A_DO_S, 32'h0000_00F0); check("R4 set", pad_out, 32'h0000_00FF);
        wr(A_DO_C, 32'h0000_0003); check("R4 clear", pad_out, 32'h0000_00FC);
        rd(A_DOUT, d);             check("R4 readback", d, 32'h0000_00FC);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(A_RI, 32'h48);
        wr(A_FA, 32'h50);
        pins(32'h58);
        wait_cyc(2);
        rd(A_STAT, d); check("R5/R9 rise", d, 32'h48);
        wr(A_STAT, 32'h48);
        pins(32'h0);
        wait_cyc(2);
        rd(A_STAT, d); check("R5/R9 fall", d, 32'h50);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_RI, 32'h0);
        wr(A_FA, 32'h0);
        rd(A_STAT, d); check("R5 cleaned", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(A_HI, 32'h200);
        pins(32'h200);
        wait_cyc(2);
        rd(A_STAT, d); check("R6 high set", d, 32'h200);
        wr(A_STAT, 32'h200);
        rd(A_STAT, d); check("R6 reasserts", d, 32'h200);
        pins(32'h0);
        wait_cyc(3);
        wr(A_STAT, 32'h200);
        rd(A_STAT, d); check("R6 gone", d, 32'h0);
        wr(A_HI, 32'h0);
        wr(A_LO, 32'h400);
        rd(A_STAT, d); check("R6 low set", d, 32'h400);
        wr(A_LO, 32'h0);
        wr(A_STAT, 32'h400);
        rd(A_STAT, d); check("R6 low gone", d, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(A_RI, 32'h3000);
        pins(32'h3000);
        wait_cyc(3);
        wr(A_STAT, 32'h1000);
        rd(A_STAT, d); check("R7 partial", d, 32'h2000);
        wr(A_STAT, 32'h2000);
        rd(A_STAT, d); check("R7 all", d, 32'h0);
        wr(A_RI, 32'h0);
        pins(32'h0);
        wait_cyc(3);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(A_RI, 32'h80);
        pins(32'h80);
        wait_cyc(3);
        pins(32'h0);
        wait_cyc(3);
        rd(A_STAT, d); check("R8 pre", d, 32'h80);
        pins(32'h80);
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h80;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_STAT, d); check("R8 detect wins", d, 32'h80);
        wr(A_STAT, 32'h80);
        rd(A_STAT, d); check("R7 edge clears", d, 32'h0);
        wr(A_RI, 32'h0);
        pins(32'h0);
        wait_cyc(3);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(A_HI, 32'h0010_0000);
        pins(32'h0010_0000);
        wait_cyc(3);
        check("R10 masked", {31'b0, irq_req}, 32'h0);
        wr(A_IEN_S, 32'h0010_0000);
        check("R10 set alias", {31'b0, irq_req}, 32'h1);
        rd(A_IEN, d); check("R10 ien read", d, 32'h0010_0000);
        wr(A_IEN_C, 32'h0010_0000);
        check("R10 clear alias", {31'b0, irq_req}, 32'h0);
        wr(A_IEN, 32'h0010_0000);
        check("R10 rw", {31'b0, irq_req}, 32'h1);
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        check("R11 idle", {31'b0, wake_req}, 32'h0);
        wr(A_WEN_S, 32'h0010_0000);
        check("R11 set alias", {31'b0, wake_req}, 32'h1);
        rd(A_WEN_S, d); check("R11 alias read", d, 32'h0010_0000);
        wr(A_WEN_C, 32'h0010_0000);
        check("R11 clear alias", {31'b0, wake_req}, 32'h0);
        rd(A_WEN_S, d); check("R11 alias read 0", d, 32'h0);
        wr(A_HI, 32'h0);
        pins(32'h0);
        wait_cyc(3);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(A_IEN, 32'hFFFF_FFFF);
        pins(32'hFFFF_FFFF);
        wait_cyc(4);
        pins(32'h0);
        wait_cyc(4);
        rd(A_STAT, d); check("R12 status", d, 32'h0);
        check("R12 irq", {31'b0, irq_req}, 32'h0);
        wr(A_IEN, 32'h0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data_in();
        t_direction();
        t_data_out();
        t_edges();
        t_level();
        t_w1c();
        t_collision();
        t_irq();
        t_wake();
        t_ignored();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule